// File: doc/BRIEF.md
# Linked-Descriptor Peripheral DMA Engine

This block is a single-channel DMA engine that carries 32-bit words between system memory and one fixed peripheral FIFO address. Work is described by descriptors that sit in memory and point to one another. Software loads the address of the first descriptor into a 64-bit control register, with the start and wide-address flags held in the low bits. The engine then walks the chain by itself.

For each descriptor the engine reads the descriptor words. It then moves the stated number of words in either direction. The memory side can be strided: blocks of words are separated by a gap. When the data is done, the engine writes a completion code back into the descriptor and pulses an interrupt if the descriptor asks for one. It then moves on to the next descriptor. A null next pointer ends the chain and sets a done flag.

The memory port and the peripheral port both use a request/acknowledge handshake. The engine holds a request, with its address and data, until the acknowledge arrives. Read data is taken in the cycle of the acknowledge.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy, done and irq are 0 and neither mem_req nor per_req is asserted.
- R2: A control write while idle clears done. Bit 0 of the written value is the start flag and bit 1 is the wide-address flag. With bit 0 set, the engine begins fetching at the written value with its two low bits cleared. With bit 0 clear, the engine stays idle.
- R3: A descriptor is 11 words at consecutive word addresses. By word offset they are: 0 next pointer low, 1 memory address low, 2 peripheral address, 3 length, 4 step, 5 block count, 6 command, 7 status, 8 next pointer high, 9 memory address high, 10 reserved. The engine reads offsets 0 to 9 in order, and each request is held stable until it is acknowledged.
- R4: Length counts 32-bit words per block. Block count is the number of blocks. Step is the gap in words between the end of one block and the start of the next. Word w of block b is at memory byte address mem + 4*(b*(length+step)+w).
- R5: Bit 1 of the command set means each word is read from memory and then written to the peripheral address. Bit 1 clear means each word is read from the peripheral address and then written to memory. The two ports are never requested in the same cycle.
- R6: Bit 0 of the command set produces a one-cycle irq pulse after that descriptor's status write-back. Bit 0 clear produces no pulse.
- R7: After a descriptor's data moves, the engine writes 32'h0000_0001 to its status word (offset 7).
- R8: The next pointer (high:low) with its two low bits cleared is fetched next. A zero next pointer ends the chain: busy falls and done rises.
- R9: With the wide flag clear, the high words (offsets 8 and 9) and control bits 63:32 are treated as zero, so mem_addr[63:32] stays 0. With the flag set, data accesses carry the memory high word in mem_addr[63:32].
- R10: A length or block count of zero makes no data access, but the status is still written back and the interrupt rule still applies.
- R11: Control writes while busy are ignored and do not disturb the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 64 | Control value: descriptor pointer, bit 1 wide flag, bit 0 start |
| busy | output | 1 | Engine is walking a chain |
| done | output | 1 | The last chain ended at a null pointer |
| irq | output | 1 | One-cycle interrupt pulse per flagged descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| per_req | output | 1 | Peripheral request |
| per_we | output | 1 | Peripheral write when 1, read when 0 |
| per_addr | output | 32 | Peripheral FIFO address |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, valid with per_ack |
| per_ack | input | 1 | Peripheral acknowledge |

## Verification
The bench drives a strided transfer whose block gap is not zero. A cursor that ignored the step, or added it after every word, would send the wrong words to the peripheral. It checks that the low bits of a next pointer are masked, because an engine that kept them would fetch misaligned descriptor words. It runs a wide-flag-clear descriptor with non-zero high words. An engine that used those words would follow a phantom next pointer or drive a non-zero upper address. It also covers zero-length descriptors, which a naive counter would run for 2^32 words, and control writes made mid-chain, which a careless engine would take as a restart.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 64;
    localparam int IDX_W      = 4;
    localparam int FETCH_LAST = 9;   // last descriptor word read
    localparam int STATUS_OFS = 7;   // word offset of status
    localparam int START_BIT  = 0;
    localparam int WIDE_BIT   = 1;
    localparam int CMD_IRQ    = 0;
    localparam int CMD_TOPER  = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] next;
        logic [ADDR_W-1:0] mem;
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] step;
        logic [DATA_W-1:0] count;
        logic              irq_en;
        logic              to_per;
    } desc_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_SETUP, S_MRD, S_PWR, S_PRD, S_MWR, S_WB
    } state_t;

    function automatic logic [ADDR_W-1:0] word_ofs(input logic [IDX_W-1:0] i);
        return {{(ADDR_W-IDX_W-2){1'b0}}, i, 2'b00};
    endfunction
endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store import dma_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    output desc_t             desc
);
    logic [DATA_W-1:0] nxt_lo, nxt_hi, mem_lo, mem_hi, per_q, len_q, step_q, cnt_q;
    logic [1:0]        cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_lo <= '0; nxt_hi <= '0; mem_lo <= '0; mem_hi <= '0;
            per_q  <= '0; len_q  <= '0; step_q <= '0; cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (load) begin
            case (idx)
                4'd0: nxt_lo <= wdata;
                4'd1: mem_lo <= wdata;
                4'd2: per_q  <= wdata;
                4'd3: len_q  <= wdata;
                4'd4: step_q <= wdata;
                4'd5: cnt_q  <= wdata;
                4'd6: cmd_q  <= {wdata[CMD_TOPER], wdata[CMD_IRQ]};
                4'd8: nxt_hi <= wdata;
                4'd9: mem_hi <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        desc.next   = {wide ? nxt_hi : '0, nxt_lo};
        desc.mem    = {wide ? mem_hi : '0, mem_lo};
        desc.per    = per_q;
        desc.len    = len_q;
        desc.step   = step_q;
        desc.count  = cnt_q;
        desc.irq_en = cmd_q[0];
        desc.to_per = cmd_q[1];
    end
endmodule

// File: rtl/dma_cursor.sv
module dma_cursor import dma_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] len,
    input  logic [DATA_W-1:0] step,
    input  logic [DATA_W-1:0] count,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [DATA_W-1:0] word_q, blk_q;
    logic              end_blk;

    assign end_blk = (word_q == len - 32'd1);
    assign last    = end_blk && (blk_q == count - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0; word_q <= '0; blk_q <= '0;
        end else if (init) begin
            addr <= base; word_q <= '0; blk_q <= '0;
        end else if (adv) begin
            if (end_blk) begin
                word_q <= '0;
                blk_q  <= blk_q + 32'd1;
                addr   <= addr + 64'd4 + {{(ADDR_W-DATA_W-2){1'b0}}, step, 2'b00};
            end else begin
                word_q <= word_q + 32'd1;
                addr   <= addr + 64'd4;
            end
        end
    end
endmodule

// File: rtl/chain_dma.sv
module chain_dma import dma_pkg::*; #(
    parameter int          CFG_BITS  = 2,
    parameter logic [31:0] DONE_CODE = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [ADDR_W-1:0] ctrl_wdata,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              per_req,
    output logic              per_we,
    output logic [DATA_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ack
);
    localparam logic [ADDR_W-1:0] PTR_MASK = ~((64'd1 << CFG_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] STAT_OFS = 64'(STATUS_OFS * 4);

    state_t            state;
    desc_t             desc;
    logic [ADDR_W-1:0] desc_ptr, cur_addr, start_ptr;
    logic [IDX_W-1:0]  idx;
    logic              wide_q, done_q, irq_q;
    logic [DATA_W-1:0] data_q;
    logic              ld, cur_init, adv, cur_last, empty;

    assign ld       = (state == S_FETCH) && mem_ack;
    assign cur_init = (state == S_SETUP);
    assign adv      = ((state == S_PWR) && per_ack) || ((state == S_MWR) && mem_ack);
    assign empty    = (desc.len == '0) || (desc.count == '0);
    assign start_ptr = ctrl_wdata[WIDE_BIT] ? ctrl_wdata
                                            : {{(ADDR_W-DATA_W){1'b0}}, ctrl_wdata[DATA_W-1:0]};

    dma_desc_store u_store (
        .clk(clk), .rst(rst), .load(ld), .idx(idx), .wdata(mem_rdata),
        .wide(wide_q), .desc(desc)
    );

    dma_cursor u_cursor (
        .clk(clk), .rst(rst), .init(cur_init), .base(desc.mem), .len(desc.len),
        .step(desc.step), .count(desc.count), .adv(adv), .addr(cur_addr), .last(cur_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; desc_ptr <= '0; idx <= '0; wide_q <= 1'b0;
            done_q <= 1'b0; irq_q <= 1'b0; data_q <= '0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                S_IDLE: if (ctrl_wr) begin
                    done_q <= 1'b0;
                    wide_q <= ctrl_wdata[WIDE_BIT];
                    if (ctrl_wdata[START_BIT]) begin
                        desc_ptr <= start_ptr & PTR_MASK;
                        idx      <= '0;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: if (mem_ack) begin
                    idx <= idx + 4'd1;
                    if (idx == IDX_W'(FETCH_LAST)) state <= S_SETUP;
                end
                S_SETUP: state <= empty ? S_WB : (desc.to_per ? S_MRD : S_PRD);
                S_MRD: if (mem_ack) begin
                    data_q <= mem_rdata;
                    state  <= S_PWR;
                end
                S_PWR: if (per_ack) state <= cur_last ? S_WB : S_MRD;
                S_PRD: if (per_ack) begin
                    data_q <= per_rdata;
                    state  <= S_MWR;
                end
                S_MWR: if (mem_ack) state <= cur_last ? S_WB : S_PRD;
                S_WB: if (mem_ack) begin
                    irq_q <= desc.irq_en;
                    if (desc.next == '0) begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        desc_ptr <= desc.next & PTR_MASK;
                        idx      <= '0;
                        state    <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        per_req = 1'b0; per_we = 1'b0; per_addr = desc.per; per_wdata = data_q;
        case (state)
            S_FETCH: begin mem_req = 1'b1; mem_addr = desc_ptr + word_ofs(idx); end
            S_MRD:   begin mem_req = 1'b1; mem_addr = cur_addr; end
            S_MWR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_addr; mem_wdata = data_q; end
            S_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_ptr + STAT_OFS; mem_wdata = DONE_CODE; end
            S_PWR:   begin per_req = 1'b1; per_we = 1'b1; end
            S_PRD:   per_req = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = done_q;
    assign irq  = irq_q;

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("mem request dropped or changed before ack");
    p_per_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (per_req && !per_ack) |=> (per_req && $stable(per_we)))
        else $error("peripheral request dropped before ack");
    p_one_port_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && per_req))
        else $error("both ports requested together");
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq)
        else $error("irq wider than one cycle");
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("done while busy");
    p_narrow_hi_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !wide_q) |-> (mem_addr[63:32] == 32'd0))
        else $error("upper address bits used with wide flag clear");
endmodule

// File: tb/test_chain_dma.sv
module test_chain_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [63:0] ctrl_wdata = '0;
    logic        busy, done, irq;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        per_req, per_we, per_ack = 1'b0;
    logic [31:0] per_addr, per_wdata, per_rdata = '0;

    int checks = 0, failures = 0, cycles = 0;
    logic [31:0] mem [0:255];
    logic [31:0] plog [0:63];
    logic [31:0] palog [0:63];
    int per_n, mem_n, irq_n, prd_n;
    logic [31:0] hi_seen;

    chain_dma i_chain_dma (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .busy(busy), .done(done), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_ack(per_ack)
    );

    always #10 clk = ~clk;

    // memory and peripheral models respond on the falling edge
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        per_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_n = mem_n + 1;
            hi_seen = hi_seen | mem_addr[63:32];
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else mem_rdata <= mem[mem_addr[9:2]];
        end
        if (per_req && !per_ack) begin
            per_ack <= 1'b1;
            if (per_we) begin
                if (per_n < 64) begin plog[per_n] = per_wdata; palog[per_n] = per_addr; end
                per_n = per_n + 1;
            end else begin
                per_rdata <= 32'hA000_0000 + prd_n;
                prd_n = prd_n + 1;
            end
        end
        if (irq) irq_n = irq_n + 1;
        cycles = cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int w, input logic [63:0] nxt, input logic [63:0] m,
                            input logic [31:0] p, input logic [31:0] len, input logic [31:0] step,
                            input logic [31:0] cnt, input logic [31:0] cmd);
        mem[w+0] = nxt[31:0]; mem[w+1] = m[31:0]; mem[w+2] = p; mem[w+3] = len;
        mem[w+4] = step; mem[w+5] = cnt; mem[w+6] = cmd; mem[w+7] = 32'd0;
        mem[w+8] = nxt[63:32]; mem[w+9] = m[63:32]; mem[w+10] = 32'd0;
    endtask

    task automatic ctl(input logic [63:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic clear_counts();
        per_n = 0; mem_n = 0; irq_n = 0; prd_n = 0; hi_seen = '0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic [63:0] v);
        ctl(64'd0);
        clear_counts();
        ctl(v);
        wait_done();
    endtask

    task automatic t_reset();
        chk(!busy && !done && !irq, "R1 reset flags", {busy, done, irq}, 0);
        chk(!mem_req && !per_req, "R1 no request", {mem_req, per_req}, 0);
    endtask

    task automatic t_mem_to_per();
        for (int i = 0; i < 4; i++) mem[128+i] = 32'hC0DE_0000 + i;
        put_desc(16, 64'd0, 64'h200, 32'h1000_0010, 4, 0, 1, 32'h3);
        run(64'h40 | 64'h3);
        chk(per_n == 4, "R5 m2p word count", per_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(plog[i] == 32'hC0DE_0000 + i, "R5 m2p data", plog[i], 32'hC0DE_0000 + i);
            chk(palog[i] == 32'h1000_0010, "R5 fixed peripheral address", palog[i], 32'h1000_0010);
        end
        chk(mem[16+7] == 32'h1, "R7 status written", mem[23], 1);
        chk(irq_n == 1, "R6 irq pulse count", irq_n, 1);
        chk(done && !busy, "R8 done after null next", {done, busy}, 2'b10);
        chk(mem_n == 15, "R3 ten fetches plus data and status", mem_n, 15);
    endtask

    task automatic t_per_to_mem();
        for (int i = 0; i < 3; i++) mem[192+i] = 32'd0;
        put_desc(32, 64'd0, 64'h300, 32'h2000_0000, 3, 0, 1, 32'h0);
        run(64'h80 | 64'h1);
        for (int i = 0; i < 3; i++)
            chk(mem[192+i] == 32'hA000_0000 + i, "R5 p2m data", mem[192+i], 32'hA000_0000 + i);
        chk(per_n == 0, "R5 p2m no peripheral writes", per_n, 0);
        chk(irq_n == 0, "R6 no irq when bit0 clear", irq_n, 0);
        chk(mem[32+7] == 32'h1, "R7 status p2m", mem[39], 1);
    endtask

    task automatic t_stride();
        logic [31:0] exp [6];
        for (int i = 0; i < 12; i++) mem[128+i] = 32'hB00 + i;
        exp = '{32'hB00, 32'hB01, 32'hB05, 32'hB06, 32'hB0A, 32'hB0B};
        put_desc(48, 64'd0, 64'h200, 32'h3000_0000, 2, 3, 3, 32'h2);
        run(64'hC0 | 64'h1);
        chk(per_n == 6, "R4 stride word total", per_n, 6);
        for (int i = 0; i < 6; i++)
            chk(plog[i] == exp[i], "R4 stride order", plog[i], exp[i]);
    endtask

    task automatic t_chain();
        mem[128] = 32'h5151_5151; mem[200] = 0; mem[201] = 0;
        put_desc(64, 64'h143, 64'h320, 32'h4000_0000, 2, 0, 1, 32'h1);
        put_desc(80, 64'd0, 64'h200, 32'h4000_0004, 1, 0, 1, 32'h3);
        run(64'h100 | 64'h1);
        chk(mem[200] == 32'hA000_0000 && mem[201] == 32'hA000_0001, "R8 first link data",
            {mem[200], mem[201]}, {32'hA000_0000, 32'hA000_0001});
        chk(per_n == 1 && plog[0] == 32'h5151_5151, "R8 masked next pointer followed", plog[0], 32'h5151_5151);
        chk(mem[71] == 1 && mem[87] == 1, "R7 both statuses", {mem[71], mem[87]}, {32'd1, 32'd1});
        chk(irq_n == 2, "R6 one pulse per link", irq_n, 2);
        // control write without start: clears done, stays idle
        ctl(64'h100);
        repeat (4) @(negedge clk);
        chk(!done && !busy && !mem_req, "R2 no start bit stays idle", {done, busy, mem_req}, 0);
    endtask

    task automatic t_wide();
        mem[140] = 32'h7777_0000;
        put_desc(96, {32'h7, 32'h0}, {32'h5, 32'h230}, 32'h5000_0000, 1, 0, 1, 32'h2);
        run({32'h9, 32'h180} | 64'h1);
        chk(hi_seen == 0, "R9 narrow upper bits zero", hi_seen, 0);
        chk(done && mem_n == 12, "R9 high next ignored", mem_n, 12);
        chk(plog[0] == 32'h7777_0000, "R9 narrow data", plog[0], 32'h7777_0000);
        mem[104] = 32'd0;
        run(64'h180 | 64'h3);
        chk(hi_seen == 32'h5, "R9 wide upper bits used", hi_seen, 5);
        chk(plog[0] == 32'h7777_0000, "R9 wide data", plog[0], 32'h7777_0000);
    endtask

    task automatic t_empty();
        put_desc(112, 64'd0, 64'h200, 32'h6000_0000, 0, 0, 5, 32'h3);
        run(64'h1C0 | 64'h1);
        chk(mem_n == 11 && per_n == 0 && prd_n == 0, "R10 zero length no data", mem_n, 11);
        chk(mem[119] == 1 && irq_n == 1, "R10 status and irq still", {mem[119], 32'(irq_n)}, {32'd1, 32'd1});
        put_desc(112, 64'd0, 64'h200, 32'h6000_0000, 4, 0, 0, 32'h2);
        run(64'h1C0 | 64'h1);
        chk(mem_n == 11 && per_n == 0, "R10 zero count no data", mem_n, 11);
    endtask

    task automatic t_busy_write();
        for (int i = 0; i < 12; i++) mem[128+i] = 32'hB00 + i;
        put_desc(48, 64'd0, 64'h200, 32'h3000_0000, 2, 3, 3, 32'h2);
        ctl(64'd0);
        clear_counts();
        ctl(64'hC0 | 64'h1);
        repeat (12) @(negedge clk);
        ctl(64'd0);
        ctl(64'h1C0 | 64'h1);
        wait_done();
        repeat (5) @(negedge clk);
        chk(!busy && mem_n == 17, "R11 busy writes ignored", mem_n, 17);
        chk(per_n == 6 && plog[5] == 32'hB0B, "R11 chain intact", plog[5], 32'hB0B);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mem_to_per();
        t_per_to_mem();
        t_stride();
        t_chain();
        t_wide();
        t_empty();
        t_busy_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule